// File: doc/BRIEF.md
# Bus Tenure Watchdog with Error Capture

This block guards the address phase of a split-transaction processor bus. A master opens an address tenure by pulsing the transfer-start strobe. From that point a counter runs until the addressed slave returns the address acknowledge or until the counter reaches a programmable limit. If the limit comes first, the block completes the address phase itself by driving the acknowledge for one cycle. It then drives a transfer-error for one cycle so that the matching data phase ends with a bus error. It also sets a sticky status flag, which can raise an interrupt.

For every started tenure, the block keeps a copy of the address and the transfer attributes (type, burst, global, size). When an error occurs, this copy moves into a pair of capture registers and those registers lock. The error can be the address timeout above, a data-timeout event from an external data-tenure timer, or a transfer-error raised by some other bus agent. Later errors leave the locked values alone until software unlocks them. Unlocking re-arms the capture but does not clear the stored values. Software reaches the configuration, interrupt enable, status, limit and capture registers through a plain single-cycle write port with a combinational read-back. The block has no streaming interface, so all of its pins are plain control and status signals.

Top module: `bus_tenure_watchdog`

## Requirements
- R1: After reset, `aack_out`, `tea_out` and `irq` are 0, and the configuration (addr 0), interrupt enable (addr 1), status (addr 2), address capture (addr 3) and signal capture (addr 4) registers all read 0.
- R2: While the watchdog enable (configuration bit 1) is 0, a transfer-start strobe starts no count and the block never drives `aack_out` or `tea_out`.
- R3: With the watchdog enabled and limit L, let E0 be the clock edge at which `ts_in` is sampled high. If `aack_in` is not seen, `aack_out` is high for exactly one cycle, starting at edge E0+L+1. A limit of 0 therefore expires on the very next edge.
- R4: If `aack_in` is sampled high at any edge from E0+1 up to and including E0+L+1, the tenure ends without a timeout: `aack_out` and `tea_out` stay low and no status flag is set.
- R5: After a timeout, `tea_out` is high for exactly the one cycle that follows the `aack_out` cycle. The two outputs are never high together.
- R6: A transfer-start strobe sampled while a count is running restarts the count from zero. The new tenure's expiry is then timed from that strobe.
- R7: Status bit 0 (address timeout) is set by a timeout and status bit 1 (data timeout) is set by a `dto_in` pulse. Writing 1 to a status bit clears it, writing 0 leaves it unchanged, and a set in the same cycle wins over a clear.
- R8: `irq` is high exactly while status bit 0 and interrupt-enable bit 0 are both 1.
- R9: On a timeout, a `dto_in` pulse or a `tea_in` pulse while unlocked, the capture registers take the address and attributes of the most recent transfer-start strobe. The capture registers then lock. The signal capture register reads tt in bits 4:0, burst in bit 5, global in bit 6 and size in bits 9:7, with zeros above.
- R10: While locked, further errors of any kind leave both capture registers unchanged.
- R11: The capture unlocks on a write of any value to addr 3 or addr 4, or on a status write with bit 0 or bit 1 set. The contents read the same after the unlock, the next error captures again, and an error in the same cycle as an unlock is captured.
- R12: The limit register (addr 5) holds L in bits LIM_W+15:16 and resets to all ones. The configuration register reads the enable in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_in | input | 1 | Transfer-start strobe opening an address tenure |
| ts_addr | input | ADDR_W | Address presented with the strobe |
| ts_tt | input | 5 | Transfer type presented with the strobe |
| ts_tbst | input | 1 | Burst flag presented with the strobe |
| ts_gbl | input | 1 | Global (coherent) flag presented with the strobe |
| ts_tsiz | input | 3 | Transfer size presented with the strobe |
| aack_in | input | 1 | Address acknowledge from the slave |
| tea_in | input | 1 | Transfer-error raised by another agent |
| dto_in | input | 1 | Data-tenure timeout event from the external data timer |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| aack_out | output | 1 | Address acknowledge driven by the block on timeout |
| tea_out | output | 1 | Transfer-error driven on the data phase after a timeout |
| irq | output | 1 | Address-timeout interrupt |

## Verification
The bench builds the block with LIM_W = 6 and ADDR_W = 16. With these values the reset limit of 63 expires within about 64 cycles, so the all-ones reset value and the largest possible count are both checked directly, next to the zero-limit case and small random limits. The narrow address keeps the capture comparisons short. The widths of the counter and the capture path only scale with these parameters, so this build follows the same timing as the default build.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

  typedef struct packed {
    logic [2:0] tsiz;
    logic       gbl;
    logic       tbst;
    logic [4:0] tt;
  } xfer_attr_t;

  localparam int ATTR_W = $bits(xfer_attr_t);

  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_RUN  = 2'd1,
    WD_ACK  = 2'd2,
    WD_TEA  = 2'd3
  } wd_state_e;

  localparam logic [2:0] RA_CFG     = 3'd0;
  localparam logic [2:0] RA_IEN     = 3'd1;
  localparam logic [2:0] RA_STAT    = 3'd2;
  localparam logic [2:0] RA_ADDRCAP = 3'd3;
  localparam logic [2:0] RA_SIGCAP  = 3'd4;
  localparam logic [2:0] RA_LIMIT   = 3'd5;

  localparam int CFG_EN_BIT = 1;
  localparam int ST_AT_BIT  = 0;
  localparam int ST_DT_BIT  = 1;
  localparam int IE_AT_BIT  = 0;
  localparam int LIM_LSB    = 16;

endpackage

// File: rtl/bwd_tenure_timer.sv
module bwd_tenure_timer
  import bwd_pkg::*;
#(
  parameter int LIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ts,
  input  logic             aack_in,
  input  logic [LIM_W-1:0] limit,
  output logic             aack_drv,
  output logic             tea_drv,
  output logic             expire
);

  wd_state_e        state;
  logic [LIM_W-1:0] cnt;

  // the limit is reached while no acknowledge and no restart arrive
  assign expire = (state == WD_RUN) && en && !ts && !aack_in && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= WD_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        WD_IDLE: begin
          if (en && ts) begin
            state <= WD_RUN;
            cnt   <= '0;
          end
        end
        WD_RUN: begin
          if (!en) begin
            state <= WD_IDLE;
          end else if (ts) begin
            cnt <= '0;
          end else if (aack_in) begin
            state <= WD_IDLE;
          end else if (cnt >= limit) begin
            state <= WD_ACK;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        WD_ACK: state <= WD_TEA;
        WD_TEA: begin
          if (en && ts) begin
            state <= WD_RUN;
            cnt   <= '0;
          end else begin
            state <= WD_IDLE;
          end
        end
        default: state <= WD_IDLE;
      endcase
    end
  end

  assign aack_drv = (state == WD_ACK);
  assign tea_drv  = (state == WD_TEA);

  AST_ACK_THEN_TEA: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WD_ACK) |=> (state == WD_TEA)); // R5

  AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WD_IDLE && !en) |=> (state == WD_IDLE)); // R2

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WD_RUN && en && ts) |=> (state == WD_RUN && cnt == '0)); // R6

  AST_ACK_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WD_RUN && en && !ts && aack_in) |=> (state == WD_IDLE)); // R4

endmodule

// File: rtl/bwd_capture.sv
module bwd_capture
  import bwd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ts,
  input  logic [ADDR_W-1:0] ts_addr,
  input  xfer_attr_t        ts_attr,
  input  logic              err_evt,
  input  logic              unlock,
  output logic [ADDR_W-1:0] cap_addr,
  output xfer_attr_t        cap_attr,
  output logic              locked
);

  logic [ADDR_W-1:0] fl_addr;
  xfer_attr_t        fl_attr;
  logic              take;

  // shadow of the tenure currently on the bus
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl_addr <= '0;
      fl_attr <= '0;
    end else if (ts) begin
      fl_addr <= ts_addr;
      fl_attr <= ts_attr;
    end
  end

  assign take = err_evt && (!locked || unlock);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_attr <= '0;
      locked   <= 1'b0;
    end else if (take) begin
      cap_addr <= fl_addr;
      cap_attr <= fl_attr;
      locked   <= 1'b1;
    end else if (unlock) begin
      locked <= 1'b0;
    end
  end

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !unlock) |=> ($stable(cap_addr) && $stable(cap_attr) && locked)); // R10

  AST_UNLOCK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && !err_evt) |=> ($stable(cap_addr) && $stable(cap_attr) && !locked)); // R11

  AST_ERROR_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> locked); // R9

endmodule

// File: rtl/bwd_regs.sv
module bwd_regs
  import bwd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  input  logic              at_set,
  input  logic              dt_set,
  input  logic [ADDR_W-1:0] cap_addr,
  input  xfer_attr_t        cap_attr,
  output logic [31:0]       rdata,
  output logic              wd_en,
  output logic [LIM_W-1:0]  limit,
  output logic              st_at,
  output logic              irq,
  output logic              unlock
);

  logic ie_at;
  logic st_dt;
  logic wr_stat;
  logic clr_at;
  logic clr_dt;

  assign wr_stat = wr && (addr == RA_STAT);
  assign clr_at  = wr_stat && wdata[ST_AT_BIT];
  assign clr_dt  = wr_stat && wdata[ST_DT_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wd_en <= 1'b0;
      ie_at <= 1'b0;
      limit <= '1;
    end else if (wr) begin
      if (addr == RA_CFG)   wd_en <= wdata[CFG_EN_BIT];
      if (addr == RA_IEN)   ie_at <= wdata[IE_AT_BIT];
      if (addr == RA_LIMIT) limit <= wdata[LIM_LSB +: LIM_W];
    end
  end

  // sticky flags, write one to clear, a set wins over a clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_at <= 1'b0;
      st_dt <= 1'b0;
    end else begin
      st_at <= at_set | (st_at & ~clr_at);
      st_dt <= dt_set | (st_dt & ~clr_dt);
    end
  end

  assign unlock = wr && ((addr == RA_ADDRCAP) || (addr == RA_SIGCAP) ||
                         ((addr == RA_STAT) && (wdata[ST_AT_BIT] || wdata[ST_DT_BIT])));

  assign irq = st_at & ie_at;

  always_comb begin
    rdata = '0;
    unique case (addr)
      RA_CFG:     rdata[CFG_EN_BIT] = wd_en;
      RA_IEN:     rdata[IE_AT_BIT]  = ie_at;
      RA_STAT: begin
        rdata[ST_AT_BIT] = st_at;
        rdata[ST_DT_BIT] = st_dt;
      end
      RA_ADDRCAP: rdata[ADDR_W-1:0] = cap_addr;
      RA_SIGCAP:  rdata[ATTR_W-1:0] = cap_attr;
      RA_LIMIT:   rdata[LIM_LSB +: LIM_W] = limit;
      default:    rdata = '0;
    endcase
  end

  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !wdata[ST_AT_BIT] && st_at) |=> st_at); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    at_set |=> st_at); // R7

endmodule

// File: rtl/bus_tenure_watchdog.sv
module bus_tenure_watchdog
  import bwd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ts_in,
  input  logic [ADDR_W-1:0] ts_addr,
  input  logic [4:0]        ts_tt,
  input  logic              ts_tbst,
  input  logic              ts_gbl,
  input  logic [2:0]        ts_tsiz,
  input  logic              aack_in,
  input  logic              tea_in,
  input  logic              dto_in,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              aack_out,
  output logic              tea_out,
  output logic              irq
);

  xfer_attr_t        attr_in;
  xfer_attr_t        cap_attr;
  logic [ADDR_W-1:0] cap_addr;
  logic [LIM_W-1:0]  limit;
  logic              wd_en;
  logic              expire;
  logic              unlock;
  logic              locked;
  logic              st_at;
  logic              err_evt;

  assign attr_in = '{tsiz: ts_tsiz, gbl: ts_gbl, tbst: ts_tbst, tt: ts_tt};
  assign err_evt = expire | dto_in | tea_in;

  bwd_tenure_timer #(.LIM_W(LIM_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (wd_en),
    .ts       (ts_in),
    .aack_in  (aack_in),
    .limit    (limit),
    .aack_drv (aack_out),
    .tea_drv  (tea_out),
    .expire   (expire)
  );

  bwd_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .ts       (ts_in),
    .ts_addr  (ts_addr),
    .ts_attr  (attr_in),
    .err_evt  (err_evt),
    .unlock   (unlock),
    .cap_addr (cap_addr),
    .cap_attr (cap_attr),
    .locked   (locked)
  );

  bwd_regs #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .at_set   (expire),
    .dt_set   (dto_in),
    .cap_addr (cap_addr),
    .cap_attr (cap_attr),
    .rdata    (reg_rdata),
    .wd_en    (wd_en),
    .limit    (limit),
    .st_at    (st_at),
    .irq      (irq),
    .unlock   (unlock)
  );

  AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(aack_out && tea_out)); // R5

  AST_AACK_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    aack_out |-> (st_at && locked)); // R7

  AST_AACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    aack_out |=> (!aack_out && tea_out)); // R3

endmodule

// File: tb/bus_tenure_watchdog_bench.sv
module bus_tenure_watchdog_bench;
  localparam int AW = 16;
  localparam int LW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ts_in = 1'b0;
  logic [AW-1:0] ts_addr = '0;
  logic [4:0]    ts_tt = '0;
  logic          ts_tbst = 1'b0;
  logic          ts_gbl = 1'b0;
  logic [2:0]    ts_tsiz = '0;
  logic          aack_in = 1'b0;
  logic          tea_in = 1'b0;
  logic          dto_in = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          aack_out;
  logic          tea_out;
  logic          irq;

  int errors = 0;
  int checks = 0;

  // bench model of the capture path and flags
  logic          m_locked = 1'b0;
  logic [31:0]   m_addr = '0;
  logic [31:0]   m_sig = '0;
  logic [31:0]   cur_addr = '0;
  logic [31:0]   cur_sig = '0;
  logic          m_at = 1'b0;

  always #4 clk = ~clk;

  bus_tenure_watchdog #(.ADDR_W(AW), .LIM_W(LW)) u_bus_tenure_watchdog (
    .clk(clk), .rst_n(rst_n), .ts_in(ts_in), .ts_addr(ts_addr), .ts_tt(ts_tt),
    .ts_tbst(ts_tbst), .ts_gbl(ts_gbl), .ts_tsiz(ts_tsiz), .aack_in(aack_in),
    .tea_in(tea_in), .dto_in(dto_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .aack_out(aack_out),
    .tea_out(tea_out), .irq(irq)
  );

  function automatic logic [31:0] sig_word(logic [4:0] tt, logic tbst, logic gbl, logic [2:0] tsiz);
    return {22'd0, tsiz, gbl, tbst, tt};
  endfunction

  function automatic logic [31:0] limit_word(int l);
    return 32'(l) << 16;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic start(logic [31:0] a, logic [4:0] tt, logic tb, logic gb, logic [2:0] sz);
    @(negedge clk);
    ts_in = 1'b1; ts_addr = a[AW-1:0]; ts_tt = tt; ts_tbst = tb; ts_gbl = gb; ts_tsiz = sz;
    cur_addr = {16'd0, a[AW-1:0]};
    cur_sig = sig_word(tt, tb, gb, sz);
    @(negedge clk);
    ts_in = 1'b0;
  endtask

  // counts negedges after the strobe edge; ack_at = edge index where aack_in is sampled
  task automatic watch(int maxc, int ack_at, output int a_first, output int a_cnt,
                       output int t_first, output int t_cnt);
    a_first = -1; a_cnt = 0; t_first = -1; t_cnt = 0;
    for (int n = 1; n <= maxc; n++) begin
      if (n == ack_at) aack_in = 1'b1;
      @(negedge clk);
      aack_in = 1'b0;
      if (aack_out) begin a_cnt++; if (a_first < 0) a_first = n; end
      if (tea_out) begin t_cnt++; if (t_first < 0) t_first = n; end
    end
  endtask

  task automatic model_error();
    if (!m_locked) begin
      m_addr = cur_addr; m_sig = cur_sig; m_locked = 1'b1;
    end
  endtask

  task automatic check_capture(string req);
    logic [31:0] d;
    rd(3'd3, d); chk(req, "address capture", d, m_addr);
    rd(3'd4, d); chk(req, "signal capture", d, m_sig);
  endtask

  task automatic check_timeout(string req, int l, int af, int ac, int tf, int tc);
    chk(req, "aack_out first cycle", 32'(af), 32'(l + 1));
    chk(req, "aack_out width", 32'(ac), 32'd1);
    chk("R5", "tea_out first cycle", 32'(tf), 32'(l + 2));
    chk("R5", "tea_out width", 32'(tc), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int af, ac, tf, tc;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R12 limit reset all ones
    chk("R1", "aack_out", 32'(aack_out), 0);
    chk("R1", "tea_out", 32'(tea_out), 0);
    chk("R1", "irq", 32'(irq), 0);
    rd(3'd0, d); chk("R1", "config", d, 0);
    rd(3'd1, d); chk("R1", "int enable", d, 0);
    rd(3'd2, d); chk("R1", "status", d, 0);
    rd(3'd3, d); chk("R1", "address capture", d, 0);
    rd(3'd4, d); chk("R1", "signal capture", d, 0);
    rd(3'd5, d); chk("R12", "limit reset", d, limit_word(63));

    // R2 disabled watchdog ignores the strobe
    start(32'h1111, 5'h03, 1'b0, 1'b1, 3'd2);
    watch(70, 0, af, ac, tf, tc);
    chk("R2", "aack_out pulses while disabled", 32'(ac), 0);
    chk("R2", "tea_out pulses while disabled", 32'(tc), 0);
    rd(3'd2, d); chk("R2", "status while disabled", d, 0);

    // R3/R12 reset limit (max count) expiry
    wr(3'd0, 32'h2);
    rd(3'd0, d); chk("R12", "config enable readback", d, 32'h2);
    start(32'hA5A5, 5'h1A, 1'b1, 1'b0, 3'd5);
    watch(70, 0, af, ac, tf, tc);
    check_timeout("R3", 63, af, ac, tf, tc);
    model_error(); m_at = 1'b1;
    rd(3'd2, d); chk("R7", "status after timeout", d, 32'h1);
    chk("R8", "irq with enable off", 32'(irq), 0);
    check_capture("R9");

    // R3 zero limit, R8 irq, R10 lock holds
    wr(3'd5, 32'h0);
    wr(3'd1, 32'h1);
    chk("R8", "irq with enable on", 32'(irq), 1);
    start(32'h0BEE, 5'h05, 1'b0, 1'b0, 3'd1);
    watch(5, 0, af, ac, tf, tc);
    check_timeout("R3", 0, af, ac, tf, tc);
    model_error();
    check_capture("R10");

    // R7 zero write keeps, one write clears; R11 unlock keeps contents
    wr(3'd2, 32'h0);
    rd(3'd2, d); chk("R7", "status after writing zero", d, 32'h1);
    wr(3'd2, 32'h1); m_locked = 1'b0; m_at = 1'b0;
    rd(3'd2, d); chk("R7", "status after writing one", d, 32'h0);
    chk("R8", "irq after clear", 32'(irq), 0);
    check_capture("R11");

    // R6 restart reloads the count
    wr(3'd5, limit_word(5));
    start(32'h0C0C, 5'h01, 1'b0, 1'b0, 3'd0);
    repeat (3) @(negedge clk);
    start(32'h0D0D, 5'h11, 1'b1, 1'b1, 3'd7);
    watch(10, 0, af, ac, tf, tc);
    check_timeout("R6", 5, af, ac, tf, tc);
    model_error(); m_at = 1'b1;
    check_capture("R9");

    // R4 ack at last allowed edge
    start(32'h0E0E, 5'h02, 1'b1, 1'b0, 3'd3);
    watch(10, 6, af, ac, tf, tc);
    chk("R4", "aack_out with late ack", 32'(ac), 0);
    chk("R4", "tea_out with late ack", 32'(tc), 0);

    // R7 data timeout flag, R10 held through it
    @(negedge clk); dto_in = 1'b1; @(negedge clk); dto_in = 1'b0;
    model_error();
    rd(3'd2, d); chk("R7", "status after data timeout", d, 32'h3);
    check_capture("R10");
    wr(3'd2, 32'h2); m_locked = 1'b0;
    rd(3'd2, d); chk("R7", "status after clearing bit 1", d, 32'h1);

    // R9 external transfer error captures the in-flight tenure
    start(32'h0F0F, 5'h1F, 1'b0, 1'b1, 3'd4);
    watch(3, 1, af, ac, tf, tc);
    @(negedge clk); tea_in = 1'b1; @(negedge clk); tea_in = 1'b0;
    model_error();
    check_capture("R9");
    wr(3'd3, 32'hDEAD); m_locked = 1'b0;
    check_capture("R11");
    start(32'h1234, 5'h0A, 1'b1, 1'b1, 3'd6);
    watch(3, 2, af, ac, tf, tc);
    @(negedge clk); dto_in = 1'b1; @(negedge clk); dto_in = 1'b0;
    model_error();
    check_capture("R11");
    wr(3'd4, 32'h0); m_locked = 1'b0;
    wr(3'd2, 32'h3); m_at = 1'b0;

    // random tenures against the bench model
    for (int it = 0; it < 40; it++) begin
      int l = int'($urandom_range(0, 12));
      int ack_at = ($urandom_range(0, 1) == 1) ? int'($urandom_range(1, l + 1)) : 0;
      logic ie = 1'($urandom_range(0, 1));
      wr(3'd5, limit_word(l));
      wr(3'd1, {31'd0, ie});
      start($urandom, 5'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
      watch(l + 5, ack_at, af, ac, tf, tc);
      if (ack_at == 0) begin
        check_timeout("R3", l, af, ac, tf, tc);
        model_error(); m_at = 1'b1;
      end else begin
        chk("R4", "aack_out after slave ack", 32'(ac), 0);
        chk("R4", "tea_out after slave ack", 32'(tc), 0);
      end
      rd(3'd2, d); chk("R7", "random status", d, {31'd0, m_at});
      chk("R8", "random irq", 32'(irq), 32'(m_at & ie));
      check_capture(m_locked ? "R10" : "R9");
      if ($urandom_range(0, 1) == 1) begin
        wr(3'd2, 32'h1); m_locked = 1'b0; m_at = 1'b0;
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule